// File: doc/BRIEF.md
# Instruction Fetch Protection Checker

This block screens each instruction fetch address against four programmable protection windows and a fallback entry. Every window has a base address, a size picked from a fixed set of powers of two, an enable bit, and three attribute bits: supervisor-only, guarded and compressed code. When a fetch lands in one or more enabled windows, the lowest-numbered one supplies the attributes. When it lands in none, the fallback entry supplies them.

A fetch is presented with a one-cycle `fetch_valid` strobe, along with its privilege level and whether it is speculative. On the next cycle the block reports a protection fault, a separate guarded-fetch fault flag and the compressed-code attribute that applies to the address. An external enable input, normally driven from the processor's translation-enable state, switches all checking on or off. Software configures the windows through a small word-wide write/read port.

Top module: `fmpu_top`

## Requirements
- R1: After reset every window word and the fallback word read back as zero, so all windows are disabled and the fallback allows both privilege levels, is unguarded and is not compressed. `prot_fault`, `guard_fault` and `code_compressed` are low.
- R2: Config addresses 0 to 3 select window words, laid out as follows. Bits [31:11] hold the base, bits [8:4] hold the size code, bit 3 is enable, bit 2 is compressed, bit 1 is guarded and bit 0 is supervisor-only. Address 4 selects the fallback word, which holds compressed, guarded and supervisor-only in bits [2:0]. Unused bits read as zero, and writes to other addresses have no effect.
- R3: Size code 0 covers 2 KB. Code k from 1 to 20 covers 2^(12+k) bytes, so 4 KB cannot be chosen. Codes above 20 cover the whole 4 GB space. Base bits below the window size are ignored when matching.
- R4: A window whose enable bit is clear never matches.
- R5: When several enabled windows match, the lowest-numbered one alone supplies the attributes.
- R6: A fetch that matches no enabled window takes its attributes from the fallback word.
- R7: With protection on, a user-level fetch (`fetch_user`=1) to supervisor-only space raises `prot_fault`. A supervisor-level fetch never faults because of privilege.
- R8: With protection on, a speculative fetch to guarded space raises both `prot_fault` and `guard_fault`. A non-speculative fetch to guarded space does not fault.
- R9: With `prot_en` low no fault is raised, and `code_compressed` follows the fallback word's compressed bit.
- R10: The outputs update on the clock edge that samples `fetch_valid` high. The fault outputs are one-cycle pulses, and `code_compressed` holds its value while no fetch is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration word select |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational) |
| prot_en | input | 1 | Global protection checking enable |
| fetch_valid | input | 1 | Fetch present this cycle |
| fetch_addr | input | 32 | Fetch byte address |
| fetch_user | input | 1 | 1 = user level, 0 = supervisor |
| fetch_spec | input | 1 | Fetch is speculative |
| prot_fault | output | 1 | Protection fault pulse |
| guard_fault | output | 1 | Speculative guarded fetch fault pulse |
| code_compressed | output | 1 | Compressed attribute of the last fetch |

## Verification
The bench builds the block with its defaults: a 32-bit address and four windows. With these values the largest size codes reach the full 4 GB space, so codes that saturate and windows that cover every address can be tested. They also allow every overlap pattern among four windows, which tests priority. Random window settings use small size codes, so that fetch addresses near a base fall on both sides of the window boundary.

// File: rtl/fmpu_pkg.sv
package fmpu_pkg;

  typedef struct packed {
    logic compressed;
    logic guard;
    logic supv_only;
  } attr_t;

  localparam int unsigned SZ_W      = 5;
  localparam int unsigned MIN_LOG2  = 11;

  // Number of low address bits a window ignores for a given size code.
  function automatic int size_log2(input logic [SZ_W-1:0] code, input int aw);
    int lg;
    if (code == '0) lg = MIN_LOG2;
    else            lg = 12 + int'(code);
    if (lg > aw) lg = aw;
    return lg;
  endfunction

endpackage

// File: rtl/fmpu_rst_sync.sv
module fmpu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_sync = stage2_q;
endmodule

// File: rtl/fmpu_cfg_regs.sv
module fmpu_cfg_regs
  import fmpu_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int NUM_REGIONS = 4,
  localparam int BASE_W     = ADDR_W - MIN_LOG2,
  localparam int RA_W       = $clog2(NUM_REGIONS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [RA_W-1:0]     cfg_addr,
  input  logic [ADDR_W-1:0]   cfg_wdata,
  output logic [ADDR_W-1:0]   cfg_rdata,
  output logic [BASE_W-1:0]   base_o [NUM_REGIONS],
  output logic [SZ_W-1:0]     size_o [NUM_REGIONS],
  output logic                en_o   [NUM_REGIONS],
  output attr_t               attr_o [NUM_REGIONS],
  output attr_t               dflt_o
);
  logic [BASE_W-1:0] base_q [NUM_REGIONS];
  logic [BASE_W-1:0] base_d [NUM_REGIONS];
  logic [SZ_W-1:0]   size_q [NUM_REGIONS];
  logic [SZ_W-1:0]   size_d [NUM_REGIONS];
  logic              en_q   [NUM_REGIONS];
  logic              en_d   [NUM_REGIONS];
  attr_t             attr_q [NUM_REGIONS];
  attr_t             attr_d [NUM_REGIONS];
  attr_t             dflt_q;
  attr_t             dflt_d;

  // next-state
  always_comb begin
    for (int r = 0; r < NUM_REGIONS; r++) begin
      base_d[r] = base_q[r];
      size_d[r] = size_q[r];
      en_d[r]   = en_q[r];
      attr_d[r] = attr_q[r];
      if (cfg_we && (cfg_addr == RA_W'(r))) begin
        base_d[r] = cfg_wdata[ADDR_W-1:MIN_LOG2];
        size_d[r] = cfg_wdata[8:4];
        en_d[r]   = cfg_wdata[3];
        attr_d[r] = cfg_wdata[2:0];
      end
    end
    dflt_d = dflt_q;
    if (cfg_we && (cfg_addr == RA_W'(NUM_REGIONS))) dflt_d = cfg_wdata[2:0];
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REGIONS; r++) begin
        base_q[r] <= '0;
        size_q[r] <= '0;
        en_q[r]   <= 1'b0;
        attr_q[r] <= '0;
      end
      dflt_q <= '0;
    end else begin
      for (int r = 0; r < NUM_REGIONS; r++) begin
        base_q[r] <= base_d[r];
        size_q[r] <= size_d[r];
        en_q[r]   <= en_d[r];
        attr_q[r] <= attr_d[r];
      end
      dflt_q <= dflt_d;
    end
  end

  // read mux
  always_comb begin
    cfg_rdata = '0;
    for (int r = 0; r < NUM_REGIONS; r++) begin
      if (cfg_addr == RA_W'(r)) begin
        cfg_rdata[ADDR_W-1:MIN_LOG2] = base_q[r];
        cfg_rdata[8:4]               = size_q[r];
        cfg_rdata[3]                 = en_q[r];
        cfg_rdata[2:0]               = attr_q[r];
      end
    end
    if (cfg_addr == RA_W'(NUM_REGIONS)) cfg_rdata[2:0] = dflt_q;
  end

  assign base_o = base_q;
  assign size_o = size_q;
  assign en_o   = en_q;
  assign attr_o = attr_q;
  assign dflt_o = dflt_q;
endmodule

// File: rtl/fmpu_region_match.sv
module fmpu_region_match
  import fmpu_pkg::*;
#(
  parameter int ADDR_W  = 32,
  localparam int BASE_W = ADDR_W - MIN_LOG2
) (
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic [BASE_W-1:0] base,
  input  logic [SZ_W-1:0]   size_code,
  input  logic              enable,
  output logic              hit
);
  logic [BASE_W-1:0] keep;
  int                lg;

  always_comb begin
    lg = size_log2(size_code, ADDR_W);
    for (int i = 0; i < BASE_W; i++) begin
      keep[i] = ((i + int'(MIN_LOG2)) >= lg);
    end
    hit = enable &&
          (((fetch_addr[ADDR_W-1:MIN_LOG2] ^ base) & keep) == '0);
  end
endmodule

// File: rtl/fmpu_resolve.sv
module fmpu_resolve
  import fmpu_pkg::*;
#(
  parameter int NUM_REGIONS = 4
) (
  input  logic [NUM_REGIONS-1:0] hits,
  input  attr_t                  attr [NUM_REGIONS],
  input  attr_t                  dflt,
  output attr_t                  sel
);
  // Scan from the top so the lowest-numbered hit is written last.
  always_comb begin
    sel = dflt;
    for (int r = NUM_REGIONS - 1; r >= 0; r--) begin
      if (hits[r]) sel = attr[r];
    end
  end
endmodule

// File: rtl/fmpu_top.sv
module fmpu_top
  import fmpu_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int NUM_REGIONS = 4,
  localparam int BASE_W     = ADDR_W - MIN_LOG2,
  localparam int RA_W       = $clog2(NUM_REGIONS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [RA_W-1:0]   cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              prot_en,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_user,
  input  logic              fetch_spec,
  output logic              prot_fault,
  output logic              guard_fault,
  output logic              code_compressed
);
  logic              rst_n_int;
  logic [BASE_W-1:0] base [NUM_REGIONS];
  logic [SZ_W-1:0]   size [NUM_REGIONS];
  logic              en   [NUM_REGIONS];
  attr_t             attr [NUM_REGIONS];
  attr_t             dflt;
  attr_t             sel;
  logic [NUM_REGIONS-1:0] hits;

  logic pf_d, pf_q, gf_d, gf_q, cc_d, cc_q;

  fmpu_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  fmpu_cfg_regs #(.ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .base_o    (base),
    .size_o    (size),
    .en_o      (en),
    .attr_o    (attr),
    .dflt_o    (dflt)
  );

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_win
    fmpu_region_match #(.ADDR_W(ADDR_W)) u_match (
      .fetch_addr (fetch_addr),
      .base       (base[r]),
      .size_code  (size[r]),
      .enable     (en[r]),
      .hit        (hits[r])
    );
  end

  fmpu_resolve #(.NUM_REGIONS(NUM_REGIONS)) u_res (
    .hits (hits),
    .attr (attr),
    .dflt (dflt),
    .sel  (sel)
  );

  // next-state
  always_comb begin
    pf_d = fetch_valid && prot_en &&
           ((fetch_user && sel.supv_only) || (fetch_spec && sel.guard));
    gf_d = fetch_valid && prot_en && fetch_spec && sel.guard;
    cc_d = cc_q;
    if (fetch_valid) cc_d = prot_en ? sel.compressed : dflt.compressed;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      pf_q <= 1'b0;
      gf_q <= 1'b0;
      cc_q <= 1'b0;
    end else begin
      pf_q <= pf_d;
      gf_q <= gf_d;
      cc_q <= cc_d;
    end
  end

  assign prot_fault      = pf_q;
  assign guard_fault     = gf_q;
  assign code_compressed = cc_q;
endmodule

// File: rtl/fmpu_checker.sv
module fmpu_checker (
  input logic clk,
  input logic rst_n,
  input logic prot_en,
  input logic fetch_valid,
  input logic fetch_user,
  input logic fetch_spec,
  input logic prot_fault,
  input logic guard_fault,
  input logic code_compressed
);
  AST_GUARD_IMPLIES_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    guard_fault |-> prot_fault); // R8

  AST_NONSPEC_NO_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_spec |=> !guard_fault); // R8

  AST_OFF_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_en |=> !prot_fault); // R9

  AST_SUPV_NONSPEC_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_user && !fetch_spec) |=> !prot_fault); // R7

  AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> (!prot_fault && !guard_fault)); // R10

  AST_ATTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> $stable(code_compressed)); // R10
endmodule

bind fmpu_top fmpu_checker u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .prot_en         (prot_en),
  .fetch_valid     (fetch_valid),
  .fetch_user      (fetch_user),
  .fetch_spec      (fetch_spec),
  .prot_fault      (prot_fault),
  .guard_fault     (guard_fault),
  .code_compressed (code_compressed)
);

// File: tb/fmpu_top_tb.sv
module fmpu_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        prot_en;
  logic        fetch_valid;
  logic [31:0] fetch_addr;
  logic        fetch_user;
  logic        fetch_spec;
  logic        prot_fault;
  logic        guard_fault;
  logic        code_compressed;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  logic [31:0] sh [5];

  always #2 clk = ~clk;

  fmpu_top #(.ADDR_W(32), .NUM_REGIONS(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .prot_en(prot_en),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_user(fetch_user),
    .fetch_spec(fetch_spec), .prot_fault(prot_fault), .guard_fault(guard_fault),
    .code_compressed(code_compressed)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int lg_of(input logic [4:0] code);
    if (code == 0) return 11;
    if (code > 20) return 32;
    return 12 + int'(code);
  endfunction

  function automatic bit win_hit(input int r, input logic [31:0] a);
    int n;
    n = lg_of(sh[r][8:4]);
    if (!sh[r][3]) return 0;
    if (n >= 32) return 1;
    return (a >> n) == (sh[r] >> n);
  endfunction

  // returns {compressed, guard, supv_only}
  function automatic logic [2:0] exp_attr(input logic [31:0] a);
    logic [2:0] s;
    s = sh[4][2:0];
    for (int r = 3; r >= 0; r--) if (win_hit(r, a)) s = sh[r][2:0];
    return s;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (a < 4)       sh[a] = d & 32'hFFFF_F9FF;
    else if (a == 4) sh[4] = d & 32'h7;
  endtask

  task automatic fetch(input string req, input logic [31:0] a, input bit user, input bit spec);
    logic [2:0] s;
    bit pf, gf, cc;
    s = exp_attr(a);
    pf = prot_en && ((user && s[0]) || (spec && s[1]));
    gf = prot_en && spec && s[1];
    cc = prot_en ? s[2] : sh[4][2];
    fetch_valid = 1; fetch_addr = a; fetch_user = user; fetch_spec = spec;
    @(negedge clk);
    fetch_valid = 0;
    chk({req, " prot_fault"}, {31'd0, prot_fault}, {31'd0, pf});
    chk({req, " guard_fault"}, {31'd0, guard_fault}, {31'd0, gf});
    chk({req, " compressed"}, {31'd0, code_compressed}, {31'd0, cc});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    bit cc_prev;
    void'($urandom(32'd1234));
    rst_n = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; prot_en = 0;
    fetch_valid = 0; fetch_addr = 0; fetch_user = 0; fetch_spec = 0;
    for (int i = 0; i < 5; i++) sh[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 prot_fault", {31'd0, prot_fault}, 0);
    chk("R1 guard_fault", {31'd0, guard_fault}, 0);
    chk("R1 compressed", {31'd0, code_compressed}, 0);
    for (int a = 0; a < 5; a++) begin
      cfg_addr = 3'(a); #1;
      chk("R1 readback", cfg_rdata, 0);
    end

    // R2 layout, unused bits, bad address ignored
    wr(3'd2, 32'hFFFF_FFFF);
    cfg_addr = 2; #1; chk("R2 window word", cfg_rdata, 32'hFFFF_F9FF);
    wr(3'd4, 32'hFFFF_FFFF);
    cfg_addr = 4; #1; chk("R2 fallback word", cfg_rdata, 32'h7);
    wr(3'd6, 32'h1234_5678);
    for (int a = 0; a < 5; a++) begin
      cfg_addr = 3'(a); #1; chk("R2 stray write", cfg_rdata, sh[a]);
    end
    cfg_addr = 6; #1; chk("R2 unmapped read", cfg_rdata, 0);
    wr(3'd2, 0); wr(3'd4, 0);

    prot_en = 1;
    // R7 supervisor-only 16 KB window at 0x10000 (code 2)
    wr(3'd0, 32'h0001_0000 | (2 << 4) | 32'h8 | 32'h1);
    fetch("R7 user in supv", 32'h0001_2000, 1, 0);
    fetch("R7 supv in supv", 32'h0001_2000, 0, 0);
    fetch("R3 above 16KB edge", 32'h0001_4000, 1, 0);
    // R3 base bits below size ignored
    wr(3'd0, 32'h0001_3800 | (2 << 4) | 32'h9);
    fetch("R3 low base bits ignored", 32'h0001_0004, 1, 0);
    // R8 guarded 2 KB window at 0x800 (code 0)
    wr(3'd1, 32'h0000_0800 | 32'h8 | 32'h2);
    fetch("R8 spec guarded", 32'h0000_0FFC, 0, 1);
    fetch("R8 nonspec guarded", 32'h0000_0800, 0, 0);
    fetch("R3 2KB upper edge", 32'h0000_1000, 0, 1);
    // R5 overlap: window 3 covers all (code 25), compressed
    wr(3'd3, (25 << 4) | 32'h8 | 32'h4);
    fetch("R5 lower wins", 32'h0001_0010, 0, 0);
    fetch("R3 saturated code", 32'hF000_0000, 0, 0);
    // R4 disable window 3, R6 fallback
    wr(3'd4, 32'h4);
    wr(3'd3, (25 << 4) | 32'h4);
    fetch("R4 disabled window", 32'hF000_0000, 0, 0);
    fetch("R6 fallback", 32'h8000_0000, 1, 1);
    // R9 protection off
    prot_en = 0;
    fetch("R9 off user supv", 32'h0001_0000, 1, 1);
    fetch("R9 off guarded", 32'h0000_0800, 0, 1);
    // R10 hold while idle
    prot_en = 1;
    fetch("R10 setup", 32'h8000_0000, 0, 0);
    cc_prev = code_compressed;
    fetch_addr = 32'h0001_0000; fetch_user = 1; fetch_spec = 1;
    repeat (3) @(negedge clk);
    chk("R10 hold compressed", {31'd0, code_compressed}, {31'd0, cc_prev});
    chk("R10 no idle fault", {31'd0, prot_fault}, 0);
    chk("R10 no idle guard", {31'd0, guard_fault}, 0);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int r;
      logic [31:0] a;
      if (($urandom % 4) == 0) begin
        logic [4:0] code;
        code = (($urandom % 8) == 0) ? 5'($urandom) : 5'($urandom % 6);
        wr(3'($urandom % 5), ($urandom & 32'hFFFF_F80F) | (32'(code) << 4));
      end
      prot_en = (($urandom % 8) != 0);
      r = $urandom % 4;
      a = sh[r] ^ ($urandom & 32'h0001_FFFF);
      fetch("R5 R6 random", a, 1'($urandom), 1'($urandom));
    end

    finish_run();
  end
endmodule